// File: doc/BRIEF.md
# Programmable Full-Duplex Serial Transceiver

This block is a full-duplex serial transceiver that software drives through a small register port. It has separate transmit and receive shift registers. Each one is backed by a one-byte buffer. Software picks the frame layout, which covers the character length, parity or a ninth data bit, and the number of stop bits. It also picks asynchronous (start/stop) or clocked synchronous operation, and a bit clock from either an internal prescaler-and-divisor chain or an external clock pin.

Status bits report the state of the two buffers, whether a character is being sent or received, and framing, overrun and parity errors. An attention mode supports multi-drop links: the receiver discards every frame whose ninth bit is clear, so that only address frames wake the host. Two interrupt request outputs follow the buffer flags, each gated by its own enable.

Register map (byte-wide, selected by `reg_addr`):

| Address | Name | Contents |
|---|---|---|
| 0 | data | a write goes to the transmit buffer; a read returns the receive buffer |
| 1 | ctrl | [7] parity enable, [6:5] parity select (bit 5 is also the transmitted ninth bit while parity is off), [4:3] length, [2] error summary, [1] receive full, [0] transmit empty |
| 2 | rxstat | [7] receiving, [6] transmitting, [5] received ninth bit, [4] attention, [2] framing, [1] overrun, [0] parity |
| 3 | mode | [7] external clock, [6] two stop bits, [5] transmit interrupt enable, [4] receive interrupt enable, [3] synchronous |
| 4 | prescale | prescaler value |
| 5 | divisor | baud divisor value |

Top module: `usart_core`

## Requirements
- R1: After reset, ctrl reads 0x01 (transmit buffer empty, all else clear), rxstat and mode read 0, `txd` and `sck_out` are 1 and both interrupt outputs are 0.
- R2: The length field ctrl[4:3] selects 00 = 7 data bits, 01 = 8 data bits, 1x = 9 bits (8 data bits plus a ninth bit). Bits go out LSB first. An asynchronous frame starts with a 0 start bit and ends with 1 stop bits. With parity off, the transmitted ninth bit is ctrl[5].
- R3: When ctrl[7] is set, a parity bit takes the ninth-bit position after the data bits. ctrl[6:5] selects 00 = odd, 01 = even, 10 = always 1, 11 = always 0. The received parity bit is stored in rxstat[5].
- R4: mode[6] = 1 sends two stop bits and 0 sends one. Between back-to-back frames the line stays high for 16 or 32 bit ticks plus one clock.
- R5: A received character goes into the receive buffer and sets ctrl[1]. The received ninth bit goes to rxstat[5]. A read of address 0 clears ctrl[1].
- R6: A 0 sampled in the stop bit sets the framing flag. A frame that completes while the buffer is full sets the overrun flag and leaves the buffer unchanged. A parity mismatch sets the parity flag. ctrl[2] is the OR of the three flags, and a read of rxstat clears them.
- R7: A write to address 0 clears ctrl[0]. The flag sets again when the buffer moves into an idle transmit shift register.
- R8: rxstat[7] is 1 while a character is being received, and rxstat[6] is 1 while a character is being shifted out.
- R9: While rxstat[4] is 1, a frame whose ninth bit is 0 leaves the receive buffer and ctrl[1] unchanged. A 9-bit frame whose ninth bit is 1 is accepted, and rxstat[4] stays set until software writes it to 0.
- R10: With the internal clock, one bit tick occurs every (prescale+1)*(divisor+1) clocks, and an asynchronous bit lasts 16 ticks.
- R11: mode[7] = 1 takes the bit ticks from rising edges of `ext_clk` instead of the internal divider.
- R12: mode[3] = 1 selects synchronous operation. Data is sent with no start or stop bit, and each bit takes one `sck_out` cycle. `txd` changes on the falling edge of `sck_out`, `rxd` is sampled on the rising edge, and `sck_out` rests high.
- R13: `tx_irq` is mode[5] AND ctrl[0], and `rx_irq` is mode[4] AND ctrl[1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (drives the clear-on-read side effects) |
| reg_addr | input | 3 | register select |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data, combinational from reg_addr |
| rxd | input | 1 | serial receive line |
| ext_clk | input | 1 | external bit-tick source |
| txd | output | 1 | serial transmit line |
| sck_out | output | 1 | synchronous-mode shift clock |
| tx_irq | output | 1 | transmit interrupt request |
| rx_irq | output | 1 | receive interrupt request |

## Verification
The assertions take several things for granted. Software does not rewrite the length, parity, stop or mode fields while a frame is in flight. It does not switch between synchronous and asynchronous operation mid-frame. In synchronous mode `rxd` holds steady around the rising edge of `sck_out`. The stimulus meets these conditions: every reconfiguration waits until the transmitter and receiver have finished, and synchronous traffic is looped back from `txd`, which only changes on the falling edge. Asynchronous frames that the stimulus injects are timed at exactly 16 ticks per bit, so mid-bit sampling sees clean levels.

// File: rtl/usart_core.sv
module usart_core #(
  parameter int OVS   = 16,
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       rxd,
  input  logic       ext_clk,
  output logic       txd,
  output logic       sck_out,
  output logic       tx_irq,
  output logic       rx_irq
);
  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_st_t;

  logic [4:0] ctrl_r;
  logic [4:0] mode_r;
  logic [DIV_W-1:0] psc_r, div_r, psc_cnt, div_cnt;
  logic par_en, ext_sel, two_stop, tx_ie, rx_ie, sync_m;
  logic [1:0] par_sel, len;
  assign {par_en, par_sel, len} = ctrl_r;
  assign {ext_sel, two_stop, tx_ie, rx_ie, sync_m} = mode_r;

  logic [3:0] dbits, nbits;
  logic has_x;
  assign dbits = (len == 2'b00) ? 4'd7 : 4'd8;
  assign has_x = par_en | len[1];
  assign nbits = dbits + {3'b0, has_x};

  // bit tick source
  logic [2:0] ext_q;
  logic tick, int_tick;
  assign int_tick = (psc_cnt == psc_r) && (div_cnt == div_r);
  assign tick = ext_sel ? (ext_q[1] & ~ext_q[2]) : int_tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_q <= '0;
      psc_cnt <= '0;
      div_cnt <= '0;
    end else begin
      ext_q <= {ext_q[1:0], ext_clk};
      if (psc_cnt == psc_r) begin
        psc_cnt <= '0;
        div_cnt <= (div_cnt == div_r) ? '0 : div_cnt + 1'b1;
      end else begin
        psc_cnt <= psc_cnt + 1'b1;
      end
    end

  // register writes
  logic attn;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_r <= '0;
      mode_r <= '0;
      psc_r <= '0;
      div_r <= '0;
      attn <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd1: ctrl_r <= reg_wdata[7:3];
        3'd2: attn <= reg_wdata[4];
        3'd3: mode_r <= reg_wdata[7:3];
        3'd4: psc_r <= DIV_W'(reg_wdata);
        3'd5: div_r <= DIV_W'(reg_wdata);
        default: ;
      endcase
    end

  // transmitter
  logic [7:0] tbuf;
  logic tbempty, tx_act, tx_first, tx_x, tx_par;
  logic [11:0] tx_sh, tx_frame;
  logic [9:0] body;
  logic [3:0] tx_left;
  logic [PH_W-1:0] tx_ph;
  logic tx_load;

  assign tx_par = ^((len == 2'b00) ? {1'b0, tbuf[6:0]} : tbuf);
  always_comb begin
    case (par_sel)
      2'b00: tx_x = ~tx_par;
      2'b01: tx_x = tx_par;
      2'b10: tx_x = 1'b1;
      default: tx_x = 1'b0;
    endcase
    if (!par_en) tx_x = par_sel[0];
    body = '1;
    for (int i = 0; i < 8; i++)
      if (4'(i) < dbits) body[i] = tbuf[i];
    if (has_x) body[dbits] = tx_x;
    tx_frame = sync_m ? {2'b11, body} : {1'b1, body, 1'b0};
  end

  assign tx_load = !tx_act && !tbempty;
  assign txd = tx_act ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tbuf <= '0;
      tbempty <= 1'b1;
      tx_act <= 1'b0;
      tx_first <= 1'b0;
      tx_sh <= '1;
      tx_left <= '0;
      tx_ph <= '0;
      sck_out <= 1'b1;
    end else begin
      if (tx_load) begin
        tx_sh <= tx_frame;
        tx_left <= sync_m ? nbits : nbits + 4'd2 + {3'b0, two_stop};
        tx_ph <= '0;
        tx_act <= 1'b1;
        tx_first <= 1'b1;
        tbempty <= 1'b1;
      end else if (tx_act && tick) begin
        if (!sync_m) begin
          if (tx_ph == PH_LAST) begin
            tx_ph <= '0;
            tx_sh <= {1'b1, tx_sh[11:1]};
            tx_left <= tx_left - 1'b1;
            if (tx_left == 4'd1) tx_act <= 1'b0;
          end else begin
            tx_ph <= tx_ph + 1'b1;
          end
        end else if (!tx_ph[0]) begin
          sck_out <= 1'b0;
          tx_ph <= PH_W'(1);
          tx_first <= 1'b0;
          if (!tx_first) tx_sh <= {1'b1, tx_sh[11:1]};
        end else begin
          sck_out <= 1'b1;
          tx_ph <= '0;
          tx_left <= tx_left - 1'b1;
          if (tx_left == 4'd1) tx_act <= 1'b0;
        end
      end
      if (reg_wr && reg_addr == 3'd0) begin
        tbuf <= reg_wdata;
        tbempty <= 1'b0;
      end
    end

  // receiver
  rx_st_t rx_st;
  logic [1:0] rxd_q;
  logic rxd_s, rx_done, rx_fe;
  logic [8:0] rx_sh, rx_frame;
  logic [3:0] rx_cnt;
  logic [PH_W-1:0] rx_ph;
  logic sync_rise;
  assign rxd_s = rxd_q[1];
  assign sync_rise = sync_m && tx_act && tick && tx_ph[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxd_q <= 2'b11;
      rx_st <= RX_IDLE;
      rx_sh <= '0;
      rx_cnt <= '0;
      rx_ph <= '0;
      rx_done <= 1'b0;
      rx_fe <= 1'b0;
    end else begin
      rxd_q <= {rxd_q[0], rxd};
      rx_done <= 1'b0;
      if (sync_rise) begin
        rx_sh <= {rxd, rx_sh[8:1]};
        if (tx_left == 4'd1) begin
          rx_done <= 1'b1;
          rx_fe <= 1'b0;
        end
      end
      case (rx_st)
        RX_IDLE:
          if (!sync_m && !rxd_s) begin
            rx_st <= RX_START;
            rx_ph <= '0;
          end
        RX_START:
          if (tick) begin
            if (rx_ph == PH_MID) begin
              rx_ph <= '0;
              rx_cnt <= '0;
              rx_st <= rxd_s ? RX_IDLE : RX_BITS;
            end else begin
              rx_ph <= rx_ph + 1'b1;
            end
          end
        RX_BITS:
          if (tick) begin
            if (rx_ph == PH_LAST) begin
              rx_ph <= '0;
              rx_sh <= {rxd_s, rx_sh[8:1]};
              rx_cnt <= rx_cnt + 1'b1;
              if (rx_cnt == nbits - 4'd1) rx_st <= RX_STOP;
            end else begin
              rx_ph <= rx_ph + 1'b1;
            end
          end
        default:
          if (tick) begin
            if (rx_ph == PH_LAST) begin
              rx_ph <= '0;
              rx_st <= RX_IDLE;
              rx_done <= 1'b1;
              rx_fe <= !rxd_s;
            end else begin
              rx_ph <= rx_ph + 1'b1;
            end
          end
      endcase
    end

  // receive buffer and status
  logic [7:0] rbuf, rx_data;
  logic rbfull, rx9, fe, ov, pe, rx_x, rx_ones, par_bad, accept, rx_busy;
  assign rx_frame = rx_sh >> (4'd9 - nbits);
  assign rx_data = (len == 2'b00) ? {1'b0, rx_frame[6:0]} : rx_frame[7:0];
  assign rx_x = rx_frame[dbits];
  assign rx_ones = ^rx_data ^ rx_x;
  assign par_bad = (par_sel == 2'b00) ? !rx_ones :
                   (par_sel == 2'b01) ? rx_ones :
                   (par_sel == 2'b10) ? !rx_x : rx_x;
  assign accept = !attn || (len[1] && rx_x);
  assign rx_busy = (rx_st != RX_IDLE) || (sync_m && tx_act);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rbuf <= '0;
      rbfull <= 1'b0;
      rx9 <= 1'b0;
      fe <= 1'b0;
      ov <= 1'b0;
      pe <= 1'b0;
    end else begin
      if (reg_rd && reg_addr == 3'd0) rbfull <= 1'b0;
      if (reg_rd && reg_addr == 3'd2) {fe, ov, pe} <= 3'b000;
      if (rx_done && accept) begin
        if (rbfull) begin
          ov <= 1'b1;
        end else begin
          rbuf <= rx_data;
          rx9 <= rx_x;
          rbfull <= 1'b1;
          if (rx_fe) fe <= 1'b1;
          if (par_en && par_bad) pe <= 1'b1;
        end
      end
    end

  assign tx_irq = tx_ie & tbempty;
  assign rx_irq = rx_ie & rbfull;

  always_comb
    case (reg_addr)
      3'd0: reg_rdata = rbuf;
      3'd1: reg_rdata = {ctrl_r, fe | ov | pe, rbfull, tbempty};
      3'd2: reg_rdata = {rx_busy, tx_act, rx9, attn, 1'b0, fe, ov, pe};
      3'd3: reg_rdata = {mode_r, 3'b000};
      3'd4: reg_rdata = 8'(psc_r);
      3'd5: reg_rdata = 8'(div_r);
      default: reg_rdata = '0;
    endcase

  p_wr_clears_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0) |=> !tbempty);
  p_load_starts_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_act && !tbempty) |=> tx_act);
  p_full_from_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rbfull) |-> $past(rx_done));
  p_status_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd2 && !rx_done) |=> !(fe | ov | pe));
  p_sck_rests_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_act |-> sck_out);
  p_attn_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && attn && !rx_x && !reg_rd) |=> $stable(rbfull));
endmodule

// File: tb/test_usart_core.sv
`timescale 1ns/1ps
module test_usart_core;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic ext_clk = 0, brx = 1, loop = 0;
  logic txd, sck_out, tx_irq, rx_irq, rxd;
  int checks = 0, errors = 0, rises = 0;

  assign rxd = loop ? txd : brx;

  usart_core i_usart_core (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd),
    .ext_clk(ext_clk), .txd(txd), .sck_out(sck_out), .tx_irq(tx_irq), .rx_irq(rx_irq));

  always #10 clk = ~clk;
  initial forever #40 ext_clk = ~ext_clk;
  always @(posedge sck_out) rises++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_full(input string req);
    logic [7:0] v;
    v = 0;
    for (int i = 0; i < 4000; i++) begin
      rd(3'd1, v);
      if (v[1]) break;
    end
    chk(req, int'(v[1]), 1);
  endtask

  task automatic flush();
    logic [7:0] v;
    rd(3'd0, v); rd(3'd2, v);
  endtask

  task automatic drive(input logic [8:0] bits, input int n, input logic stopv);
    @(negedge clk); brx = 0; repeat (16) @(negedge clk);
    for (int i = 0; i < n; i++) begin brx = bits[i]; repeat (16) @(negedge clk); end
    brx = stopv; repeat (16) @(negedge clk);
    brx = 1; repeat (16) @(negedge clk);
  endtask

  task automatic high_len(output int n);
    int g;
    g = 0; n = 0;
    while (txd !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
    while (txd !== 1'b1 && g < 5000) begin @(negedge clk); g++; end
    while (txd === 1'b1 && g < 5000) begin @(negedge clk); n++; g++; end
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic [1:0] sel);
    logic odd1;
    odd1 = ($countones(d) % 2) == 1;
    case (sel)
      2'b00: return !odd1;
      2'b01: return odd1;
      2'b10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, s, d, dm, ctrl;
    logic pen, xe;
    logic [1:0] sel;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd1, v); chk("R1 ctrl", v, 8'h01);
    rd(3'd2, v); chk("R1 rxstat", v, 0);
    rd(3'd3, v); chk("R1 mode", v, 0);
    chk("R1 lines", {txd, sck_out, tx_irq, rx_irq}, 4'b1100);

    // R2 R3 R4 R5: loopback sweep over length, parity and stop settings
    loop = 1;
    for (int ln = 0; ln < 3; ln++)
      for (int pm = 0; pm < 6; pm++)
        for (int st = 0; st < 2; st++) begin
          if (pm == 1 && ln != 2) continue;
          pen = pm >= 2;
          sel = pen ? 2'(pm - 2) : (pm == 1 ? 2'b01 : 2'b00);
          ctrl = {pen, sel, 2'(ln), 3'b000};
          wr(3'd3, st[0] ? 8'h40 : 8'h00);
          wr(3'd1, ctrl);
          for (int k = 0; k < 2; k++) begin
            d = 8'(ln * 37 + pm * 53 + st * 91 + k * 113 + 5);
            dm = (ln == 0) ? {1'b0, d[6:0]} : d;
            xe = pen ? par_of(dm, sel) : ((ln == 2) ? sel[0] : 1'b0);
            wr(3'd0, d);
            wait_full("R5 full");
            rd(3'd2, s);
            chk("R6 no error R4", s[2:0], 0);
            if (pen || ln == 2) chk("R3 ninth/parity bit", s[5], xe);
            rd(3'd0, v);
            chk("R2 data", v, dm);
            repeat (48) @(negedge clk);
            rd(3'd1, v);
            chk("R5 cleared", v[1], 0);
          end
        end

    // R4: stop time between back-to-back frames
    loop = 0;
    wr(3'd1, 8'h08);
    for (int st = 0; st < 2; st++) begin
      wr(3'd3, st[0] ? 8'h40 : 8'h00);
      wr(3'd0, 8'h00); wr(3'd0, 8'h00);
      high_len(n);
      chk("R4 stop length", n, st[0] ? 33 : 17);
      repeat (600) @(negedge clk);
      flush();
    end
    wr(3'd3, 8'h00);

    // R3 R6: parity error, even parity, 8 bits, wrong parity bit 1
    wr(3'd1, 8'hA8);
    drive({1'b1, 8'h03}, 9, 1'b1);
    rd(3'd1, v); chk("R6 summary", v[2:1], 2'b11);
    rd(3'd2, s); chk("R6 parity flag", s[2:0], 3'b001);
    rd(3'd2, s); chk("R6 clear on read", s[2:0], 0);
    rd(3'd0, v); chk("R5 data kept", v, 8'h03);

    // R6: framing error
    wr(3'd1, 8'h08);
    drive({1'b0, 8'h5A}, 8, 1'b0);
    rd(3'd2, s); chk("R6 framing", s[2:0], 3'b100);
    rd(3'd0, v); chk("R5 data framing", v, 8'h5A);

    // R6 R8: overrun, busy while receiving
    fork
      drive({1'b0, 8'h11}, 8, 1'b1);
      begin repeat (60) @(negedge clk); rd(3'd2, s); chk("R8 rx busy", s[7], 1); end
    join
    drive({1'b0, 8'h22}, 8, 1'b1);
    rd(3'd2, s); chk("R6 overrun", s[2:0], 3'b010);
    rd(3'd0, v); chk("R6 buffer kept", v, 8'h11);

    // R9: attention mode, 9-bit no parity
    wr(3'd1, 8'h10);
    wr(3'd2, 8'h10);
    drive({1'b0, 8'h55}, 9, 1'b1);
    rd(3'd1, v); chk("R9 data frame ignored", v[1], 0);
    drive({1'b1, 8'hA5}, 9, 1'b1);
    rd(3'd1, v); chk("R9 address accepted", v[1], 1);
    rd(3'd2, s); chk("R9 ninth and attn", s[5:4], 2'b11);
    rd(3'd0, v); chk("R9 address data", v, 8'hA5);
    wr(3'd2, 8'h00);
    rd(3'd2, s); chk("R9 attn cleared", s[4], 0);

    // R7 R8 R13: buffer flag, busy, interrupts
    loop = 1;
    wr(3'd1, 8'h08);
    wr(3'd3, 8'h30);
    chk("R13 tx irq", tx_irq, 1);
    wr(3'd0, 8'h12);
    rd(3'd1, v); chk("R7 moved to shifter", v[0], 1);
    rd(3'd2, s); chk("R8 tx busy", s[6], 1);
    wr(3'd0, 8'h34);
    chk("R13 tx irq low", tx_irq, 0);
    rd(3'd1, v); chk("R7 buffer held", v[0], 0);
    wait_full("R5 first");
    chk("R13 rx irq", rx_irq, 1);
    rd(3'd0, v); chk("R7 first data", v, 8'h12);
    chk("R13 rx irq low", rx_irq, 0);
    wait_full("R5 second");
    rd(3'd0, v); chk("R7 second data", v, 8'h34);
    repeat (48) @(negedge clk);
    wr(3'd3, 8'h00);
    flush();

    // R10: prescale 1, divisor 2 -> 6 clocks per tick, 96 per bit
    loop = 0;
    wr(3'd4, 8'd1); wr(3'd5, 8'd2);
    wr(3'd0, 8'h01);
    high_len(n); chk("R10 bit time", n, 96);
    repeat (1200) @(negedge clk);
    wr(3'd4, 8'd0); wr(3'd5, 8'd0);
    flush();

    // R11: external ticks every 4 clocks -> 64 per bit
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h01);
    high_len(n); chk("R11 ext bit time", n, 64);
    repeat (800) @(negedge clk);
    wr(3'd3, 8'h00);
    flush();

    // R12: synchronous loopback
    loop = 1;
    wr(3'd3, 8'h08);
    rises = 0;
    wr(3'd0, 8'hA7);
    wait_full("R12 full");
    chk("R12 clock count 8", rises, 8);
    rd(3'd0, v); chk("R12 data", v, 8'hA7);
    wr(3'd1, 8'h30);
    rises = 0;
    wr(3'd0, 8'h3C);
    wait_full("R12 full 9");
    chk("R12 clock count 9", rises, 9);
    rd(3'd2, s); chk("R12 ninth bit", s[5], 1);
    rd(3'd0, v); chk("R12 data 9", v, 8'h3C);
    wr(3'd1, 8'h00);
    rises = 0;
    wr(3'd0, 8'hFF);
    wait_full("R12 full 7");
    chk("R12 clock count 7", rises, 7);
    rd(3'd0, v); chk("R12 data 7", v, 8'h7F);
    chk("R12 sck rests high", sck_out, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule